// File: doc/BRIEF.md
# Banked Data-Space Register File with Pointer Indirection

This block is the data-space storage of a small 8-bit core whose instructions carry a 5-bit register number. The lower sixteen register numbers are shared by every bank. They hold the special registers (an indirect alias slot, a program-counter low byte, the ALU status byte and the pointer register) and a few bytes of shared RAM. The upper sixteen register numbers reach general RAM in one of `NUM_BANKS` banks.

The pointer register does two jobs. Its low five bits name a register for indirect access through the alias slot, and the bits above them select the bank for the upper half of the space, both for direct access and for indirect access. Together these bits make the pointer a flat byte pointer across every implemented bank. Pointer bits that no implemented bank uses cannot be written and always read back as ones.

The core drives one combinational read port and one write port that is clocked on the rising edge. The pointer and the status byte are also brought out directly.

Top module: `bank_regfile`

## Requirements
- R1: After reset every register reads zero and `statusOut` is 0x00, except the pointer: its unimplemented upper bits read as ones, so it reads 0x80 with the default of 4 banks.
- R2: Register numbers 1–15 are shared. A value written at one of them reads back unchanged whatever bank the pointer selects.
- R3: Register numbers 16–31 are banked. The bank index is taken from pointer bits starting at bit 5 (bits 6:5 for 4 banks), and each bank holds its own sixteen bytes.
- R4: An access to register 0 is redirected to the register numbered by pointer bits 4:0. If that number is 16 or more, the bank comes from the pointer's bank bits. An indirect write can target the pointer itself.
- R5: When pointer bits 4:0 are zero, a read of register 0 returns 0x00 and a write to register 0 changes nothing.
- R6: The pointer is at register 4 and on `ptrOut`. With the default of 4 banks, bit 7 ignores writes and always reads 1, so writing 0x25 reads back as 0xA5 and writing 0xFF reads back as 0xFF.
- R7: The status byte is at register 3 and is mirrored on `statusOut`. The program-counter low byte is at register 2. Both can be read and written.
- R8: Reads are combinational and writes take effect on the rising clock edge. A read of the register being written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddr | input | 5 | Register number for the read port |
| rdData | output | 8 | Combinational read data |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Register number for the write port |
| wrData | input | 8 | Write data |
| ptrOut | output | 8 | Pointer register as read back |
| statusOut | output | 8 | Status register |

## Verification
The hardest cases to reach are indirect accesses that land in a bank other than the one a direct access would see, and the pointer naming itself or the empty alias slot. The bench reaches them only through the port: it first writes the pointer so that its bank bits and its low bits point at different places, and then uses register 0. It proves that a dropped write had no effect by reading back every location it could have touched: the alias read, the pointer and the status byte.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 5;
  localparam int LOW_W        = ADDR_W - 1;
  localparam int BANK_FIELD_W = DATA_W - ADDR_W;
  localparam int BIDX_W       = LOW_W + BANK_FIELD_W;

  // Special register numbers; the bench and the core decode these.
  localparam logic [ADDR_W-1:0] REG_ALIAS  = 5'd0;
  localparam logic [ADDR_W-1:0] REG_PCLOW  = 5'd2;
  localparam logic [ADDR_W-1:0] REG_STATUS = 5'd3;
  localparam logic [ADDR_W-1:0] REG_PTR    = 5'd4;

  typedef struct packed {
    logic              wrShared;
    logic              wrBanked;
    logic              wrPtr;
    logic [LOW_W-1:0]  wrLow;
    logic [BIDX_W-1:0] wrBankIdx;
    logic              rdNull;
    logic              rdHigh;
    logic              rdPtr;
    logic [LOW_W-1:0]  rdLow;
    logic [BIDX_W-1:0] rdBankIdx;
  } rfCtl_t;
endpackage

// File: rtl/bank_rf_control.sv
module bank_rf_control
  import bank_rf_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] ptrVal,
  output rfCtl_t            ctl
);
  localparam logic [BANK_FIELD_W-1:0] BANK_MASK = BANK_FIELD_W'(NUM_BANKS - 1);

  logic [BANK_FIELD_W-1:0] bankSel;
  logic [ADDR_W-1:0]       rdEff;
  logic [ADDR_W-1:0]       wrEff;
  logic                    wrNull;

  generate
    if (NUM_BANKS > 1) begin : g_banked
      assign bankSel = ptrVal[DATA_W-1:ADDR_W] & BANK_MASK;
    end else begin : g_flat
      assign bankSel = '0;
    end
  endgenerate

  // Resolve alias accesses through the pointer's low bits.
  assign rdEff  = (rdAddr == REG_ALIAS) ? ptrVal[ADDR_W-1:0] : rdAddr;
  assign wrEff  = (wrAddr == REG_ALIAS) ? ptrVal[ADDR_W-1:0] : wrAddr;
  assign wrNull = (wrEff == REG_ALIAS);

  always_comb begin
    ctl           = '0;
    ctl.rdNull    = (rdEff == REG_ALIAS);
    ctl.rdHigh    = rdEff[ADDR_W-1];
    ctl.rdPtr     = (rdEff == REG_PTR);
    ctl.rdLow     = rdEff[LOW_W-1:0];
    ctl.rdBankIdx = {bankSel, rdEff[LOW_W-1:0]};
    ctl.wrLow     = wrEff[LOW_W-1:0];
    ctl.wrBankIdx = {bankSel, wrEff[LOW_W-1:0]};
    if (wrEn && !wrNull) begin
      ctl.wrBanked = wrEff[ADDR_W-1];
      ctl.wrPtr    = (wrEff == REG_PTR);
      ctl.wrShared = !wrEff[ADDR_W-1] && (wrEff != REG_PTR);
    end
  end

  // R5: an alias write while the pointer names the alias slot reaches no storage
  p_null_write_dropped_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_ALIAS && ptrVal[ADDR_W-1:0] == REG_ALIAS)
      |-> !(ctl.wrShared || ctl.wrBanked || ctl.wrPtr));

  // R4: a write, direct or redirected, lands in at most one storage group
  p_single_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrShared, ctl.wrBanked, ctl.wrPtr}));
endmodule

// File: rtl/bank_rf_datapath.sv
module bank_rf_datapath
  import bank_rf_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ptrOut,
  output logic [DATA_W-1:0] statusOut
);
  localparam int SHARED_N = 1 << LOW_W;
  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int IDX_W    = LOW_W + BANK_W;
  localparam int BANKED_N = NUM_BANKS * SHARED_N;
  localparam logic [DATA_W-1:0] PTR_KEEP = DATA_W'((1 << (ADDR_W + BANK_W)) - 1);

  logic [DATA_W-1:0] sharedMem [SHARED_N];
  logic [DATA_W-1:0] bankedMem [BANKED_N];
  logic [DATA_W-1:0] ptrReg;
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rdIdx;

  assign wrIdx = ctl.wrBankIdx[IDX_W-1:0];
  assign rdIdx = ctl.rdBankIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg <= '0;
      for (int i = 0; i < SHARED_N; i++) sharedMem[i] <= '0;
      for (int i = 0; i < BANKED_N; i++) bankedMem[i] <= '0;
    end else begin
      if (ctl.wrPtr)    ptrReg           <= wrData & PTR_KEEP;
      if (ctl.wrShared) sharedMem[ctl.wrLow] <= wrData;
      if (ctl.wrBanked) bankedMem[wrIdx] <= wrData;
    end
  end

  assign ptrOut    = ptrReg | ~PTR_KEEP;
  assign statusOut = sharedMem[REG_STATUS[LOW_W-1:0]];

  always_comb begin
    if (ctl.rdNull)      rdData = '0;
    else if (ctl.rdHigh) rdData = bankedMem[rdIdx];
    else if (ctl.rdPtr)  rdData = ptrOut;
    else                 rdData = sharedMem[ctl.rdLow];
  end

  // R6: the pointer only moves when a write is steered to it
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrPtr |=> $stable(ptrOut));

  // R7: a write steered to the status slot appears on the status output next cycle
  p_status_visible_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrShared && ctl.wrLow == REG_STATUS[LOW_W-1:0]) |=> statusOut == $past(wrData));
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_rf_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ptrOut,
  output logic [DATA_W-1:0] statusOut
);
  rfCtl_t ctl;

  bank_rf_control #(.NUM_BANKS(NUM_BANKS)) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .ptrVal(ptrOut), .ctl(ctl)
  );

  bank_rf_datapath #(.NUM_BANKS(NUM_BANKS)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .rdData(rdData), .ptrOut(ptrOut), .statusOut(statusOut)
  );

  // R5: reading the alias slot while the pointer names it yields zero
  p_null_read_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == REG_ALIAS && ptrOut[ADDR_W-1:0] == REG_ALIAS) |-> rdData == '0);
endmodule

// File: tb/bank_regfile_bench.sv
module bank_regfile_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] ptrOut;
  logic [7:0] statusOut;
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  bank_regfile u_bank_regfile (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .ptrOut(ptrOut), .statusOut(statusOut)
  );

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic t_reset_r1();
    logic [7:0] v;
    check("R1", "ptrOut", ptrOut, 8'h80);
    check("R1", "statusOut", statusOut, 8'h00);
    rd(5'd9, v);  check("R1", "shared 9", v, 8'h00);
    rd(5'd20, v); check("R1", "banked 20", v, 8'h00);
  endtask

  task automatic t_pointer_r6();
    logic [7:0] v;
    wr(5'd4, 8'hFF); @(negedge clk); check("R6", "ptr FF", ptrOut, 8'hFF);
    wr(5'd4, 8'h25); @(negedge clk); check("R6", "ptr 25", ptrOut, 8'hA5);
    rd(5'd4, v); check("R6", "ptr readport", v, 8'hA5);
  endtask

  task automatic t_shared_r2();
    logic [7:0] v;
    wr(5'd4, 8'h00); wr(5'd9, 8'h5A);
    wr(5'd4, 8'h60);
    rd(5'd9, v); check("R2", "shared 9 bank3", v, 8'h5A);
  endtask

  task automatic t_banked_r3();
    logic [7:0] v;
    wr(5'd4, 8'h00); wr(5'd20, 8'h11);
    wr(5'd4, 8'h20); wr(5'd20, 8'h22);
    rd(5'd20, v); check("R3", "bank1 20", v, 8'h22);
    wr(5'd4, 8'h00);
    rd(5'd20, v); check("R3", "bank0 20", v, 8'h11);
    wr(5'd4, 8'h60);
    rd(5'd20, v); check("R3", "bank3 20", v, 8'h00);
  endtask

  task automatic t_null_r5();
    logic [7:0] v;
    wr(5'd4, 8'h00);
    rd(5'd0, v); check("R5", "null read", v, 8'h00);
    wr(5'd0, 8'hAB);
    rd(5'd0, v); check("R5", "null read after write", v, 8'h00);
    check("R5", "ptr untouched", ptrOut, 8'h80);
    check("R5", "status untouched", statusOut, 8'h00);
    wr(5'd4, 8'h20);
    rd(5'd0, v); check("R5", "null read bank1", v, 8'h00);
  endtask

  task automatic t_indirect_r4();
    logic [7:0] v;
    wr(5'd4, 8'h15); wr(5'd0, 8'h77);
    rd(5'd21, v); check("R4", "direct 21", v, 8'h77);
    rd(5'd0, v);  check("R4", "alias 21", v, 8'h77);
    wr(5'd4, 8'h4A); wr(5'd0, 8'h33);
    wr(5'd4, 8'h00);
    rd(5'd10, v); check("R4", "shared via alias", v, 8'h33);
    wr(5'd4, 8'h54);
    rd(5'd0, v); check("R4", "alias bank2 fresh", v, 8'h00);
    wr(5'd0, 8'h44);
    wr(5'd4, 8'h40);
    rd(5'd20, v); check("R4", "bank2 20 direct", v, 8'h44);
    wr(5'd4, 8'h04); wr(5'd0, 8'h12);
    @(negedge clk); check("R4", "alias writes ptr", ptrOut, 8'h92);
  endtask

  task automatic t_status_r7();
    logic [7:0] v;
    wr(5'd3, 8'h1C); @(negedge clk);
    check("R7", "statusOut", statusOut, 8'h1C);
    rd(5'd3, v); check("R7", "status readport", v, 8'h1C);
    wr(5'd2, 8'h9D);
    rd(5'd2, v); check("R7", "pc low", v, 8'h9D);
  endtask

  task automatic t_timing_r8();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd11; wrData = 8'h66; rdAddr = 5'd11;
    #1 check("R8", "old value same cycle", rdData, 8'h00);
    @(posedge clk); #1;
    wrEn = 1'b0;
    check("R8", "new value after edge", rdData, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_pointer_r6();
    t_shared_r2();
    t_banked_r3();
    t_null_r5();
    t_indirect_r4();
    t_status_r7();
    t_timing_r8();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule